// File: doc/BRIEF.md
# Boot-Mode Entry Decision Logic

After every reset, and again after a software reset command, this block decides whether the device starts the user application or stays in the serial download loader. A reset controller pulses `start` with the reset cause, the sampled level of the download-request pin and the stored 32-bit Page 0 check word. Flash read logic then streams the Page 0 image as half words. The block adds up the image, leaving out the two half words that hold the check word. The stored word passes if it equals the fixed release key or if it matches that sum. A failing word sends the device to the loader, provided the pin condition is met.

While the loader is active, an inactivity timer runs. Each received LIN frame restarts it. If it runs out, the block raises a power-down request. The timeout is the product of a prescaler count and a tick count, and both are parameters.

Top module: `boot_mode_decider`

## Requirements
- R1: After reset and while a page is being collected, `run_user`, `enter_loader`, `page0_error` and `power_down_req` are all low. Once a decision is made, exactly one of `run_user` and `enter_loader` is high.
- R2: The Page 0 sum is the 32-bit sum of the 256 half words of the image in stream order. Half words 10 and 11, which are the check word at byte offset 0x14, are left out of the sum. A stored word equal to this sum passes and gives `run_user`.
- R3: A stored word equal to the key 0x27011970 passes and gives `run_user`, whatever the image contents.
- R4: An erased stored word (0xFFFFFFFF) never passes. It gives `enter_loader` when the pin condition is met and leaves `page0_error` low.
- R5: A stored word that is neither erased nor passing sets `page0_error`. The flag and the decision stay unchanged until the next `start` or reset.
- R6: Cause codes are power-on 2'b00, pin 2'b01, watchdog 2'b10 and software 2'b11. For power-on and pin causes, the loader is entered only when `dl_pin` was sampled low. For watchdog and software causes, the pin is not consulted. A failed check with the pin condition unmet gives `run_user`.
- R7: The decision appears in the clock cycle after the edge that accepts the 256th half word. Half words offered before `start`, or after the 256th, are ignored.
- R8: A `start` pulse clears the outputs and the sum and begins a new collection, even in the middle of a page.
- R9: While `enter_loader` is high with no frame, `power_down_req` rises exactly PRESCALE*TIMEOUT_TICKS cycles after `enter_loader` rose.
- R10: A `lin_frame_rx` pulse restarts the inactivity timer in full and clears `power_down_req` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decision (reset release or software reset command) |
| cause | input | 2 | Reset cause code, sampled on `start` |
| dl_pin | input | 1 | Download-request pin level, sampled on `start` |
| check_word | input | 32 | Stored Page 0 check word, sampled on `start` |
| hw_valid | input | 1 | Page 0 half-word strobe |
| hw_data | input | 16 | Page 0 half word |
| lin_frame_rx | input | 1 | Pulse for each received LIN frame |
| run_user | output | 1 | Decision: start the application |
| enter_loader | output | 1 | Decision: stay in the download loader |
| page0_error | output | 1 | Stored check word is invalid and not erased |
| power_down_req | output | 1 | Loader inactivity timeout expired |

## Verification
The assertions check on every cycle that:
- the two decision outputs are never both high;
- the key never leads to the loader;
- a decision and its error flag hold until the next `start`;
- the decision follows the last half word by one cycle;
- the collection counter never runs past the page;
- a frame always drops the power-down request.

Only the bench scenarios can show that the sum is right and that it leaves out exactly the check-word half words. The same holds for the pin rule depending on the reset cause, for a restart in the middle of a page discarding the partial sum, and for the exact timeout length.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_PIN = 2'b01,
    CAUSE_WDT = 2'b10,
    CAUSE_SW  = 2'b11
  } rst_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_COLLECT = 2'b01,
    ST_DECIDED = 2'b10
  } boot_state_e;

  typedef struct packed {
    logic run_user;
    logic enter_loader;
    logic page0_err;
  } verdict_t;
endpackage

// File: rtl/page0_sum.sv
module page0_sum #(
  parameter int PAGE_HW      = 256,
  parameter int CHECK_HW_IDX = 10,
  parameter int SUM_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hw_valid,
  input  logic [15:0]      hw_data,
  output logic [SUM_W-1:0] sum,
  output logic             done
);
  localparam int CNT_W = $clog2(PAGE_HW + 1);
  localparam logic [CNT_W-1:0] EXC_LO = CNT_W'(CHECK_HW_IDX);
  localparam logic [CNT_W-1:0] EXC_HI = CNT_W'(CHECK_HW_IDX + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PAGE_HW - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic             armed_q, armed_d;
  logic             done_q, done_d;
  logic             accept, excluded;

  assign accept   = armed_q && hw_valid && !clear;
  assign excluded = (cnt_q == EXC_LO) || (cnt_q == EXC_HI);

  always_comb begin
    cnt_d   = cnt_q;
    sum_d   = sum_q;
    armed_d = armed_q;
    done_d  = 1'b0;
    if (clear) begin
      cnt_d   = '0;
      sum_d   = '0;
      armed_d = 1'b1;
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
      if (!excluded) sum_d = sum_q + SUM_W'(hw_data);
      if (cnt_q == LAST) begin
        armed_d = 1'b0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sum_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  assign sum  = sum_q;
  assign done = done_q;

  // R7: collection never runs past the page
  assert_cnt_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q < CNT_W'(PAGE_HW)));
  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/boot_decide.sv
module boot_decide
  import boot_pkg::*;
#(
  parameter logic [31:0] CHECK_KEY = 32'h2701_1970,
  parameter int          SUM_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cause,
  input  logic             dl_pin,
  input  logic [31:0]      check_word,
  input  logic             sum_done,
  input  logic [SUM_W-1:0] sum,
  output logic             run_user,
  output logic             enter_loader,
  output logic             page0_error
);
  boot_state_e st_q, st_d;
  logic [1:0]  cause_q, cause_d;
  logic        pin_q, pin_d;
  logic [31:0] cw_q, cw_d;
  verdict_t    vd_q, vd_d;
  logic        key_hit, erased, sum_hit, pass, pin_ok;

  assign key_hit = (cw_q == CHECK_KEY);
  assign erased  = (cw_q == 32'hFFFF_FFFF);
  assign sum_hit = !erased && (cw_q == 32'(sum));
  assign pass    = key_hit || sum_hit;
  assign pin_ok  = ((cause_q == CAUSE_POR) || (cause_q == CAUSE_PIN)) ? !pin_q : 1'b1;

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    pin_d   = pin_q;
    cw_d    = cw_q;
    vd_d    = vd_q;
    if (start) begin
      st_d    = ST_COLLECT;
      cause_d = cause;
      pin_d   = dl_pin;
      cw_d    = check_word;
      vd_d    = '0;
    end else if (st_q == ST_COLLECT && sum_done) begin
      st_d              = ST_DECIDED;
      vd_d.enter_loader = pin_ok && !pass;
      vd_d.run_user     = !(pin_ok && !pass);
      vd_d.page0_err    = !pass && !erased;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cause_q <= '0;
      pin_q   <= 1'b0;
      cw_q    <= '0;
      vd_q    <= '0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      pin_q   <= pin_d;
      cw_q    <= cw_d;
      vd_q    <= vd_d;
    end
  end

  assign run_user     = vd_q.run_user;
  assign enter_loader = vd_q.enter_loader;
  assign page0_error  = vd_q.page0_err;

  // R1: never both decisions
  assert_onehot_decision_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vd_q.run_user, vd_q.enter_loader}));
  // R3: the key never leads to the loader
  assert_key_runs_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DECIDED && key_hit) |-> !vd_q.enter_loader);
  // R5: a decision holds until the next start
  assert_verdict_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DECIDED && !start) |=> $stable(vd_q));
  // R7: decision one cycle after the last half word
  assert_decide_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT && sum_done && !start) |=> (vd_q.run_user || vd_q.enter_loader));
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int PRESCALE      = 32768,
  parameter int TIMEOUT_TICKS = 3600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic activity,
  input  logic clear,
  output logic expire
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TIMEOUT_TICKS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] tick_q, tick_d;
  logic          exp_q, exp_d;
  logic          restart, wrap;

  assign restart = !enable || activity || clear;
  assign wrap    = (pre_q == PRE_LAST);

  always_comb begin
    pre_d  = pre_q;
    tick_d = tick_q;
    exp_d  = exp_q;
    if (restart) begin
      pre_d  = '0;
      tick_d = '0;
      exp_d  = 1'b0;
    end else if (!exp_q) begin
      pre_d = wrap ? '0 : pre_q + 1'b1;
      if (wrap) begin
        if (tick_q == TICK_LAST) exp_d = 1'b1;
        else tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
      exp_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      tick_q <= tick_d;
      exp_q  <= exp_d;
    end
  end

  assign expire = exp_q;

  // R10: a frame always drops the request
  assert_activity_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !exp_q);
  // R9: expiry only after an enabled cycle
  assert_expire_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_q) |-> $past(enable));
endmodule

// File: rtl/boot_mode_decider.sv
module boot_mode_decider #(
  parameter int          PAGE_HW        = 256,
  parameter int          CHECK_BYTE_OFS = 20,
  parameter logic [31:0] CHECK_KEY      = 32'h2701_1970,
  parameter int          PRESCALE       = 32768,
  parameter int          TIMEOUT_TICKS  = 3600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  cause,
  input  logic        dl_pin,
  input  logic [31:0] check_word,
  input  logic        hw_valid,
  input  logic [15:0] hw_data,
  input  logic        lin_frame_rx,
  output logic        run_user,
  output logic        enter_loader,
  output logic        page0_error,
  output logic        power_down_req
);
  localparam int CHECK_HW_IDX = CHECK_BYTE_OFS / 2;
  localparam int SUM_W        = 32;

  logic [SUM_W-1:0] sum;
  logic             sum_done;

  page0_sum #(.PAGE_HW(PAGE_HW), .CHECK_HW_IDX(CHECK_HW_IDX), .SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clear(start), .hw_valid(hw_valid),
    .hw_data(hw_data), .sum(sum), .done(sum_done));

  boot_decide #(.CHECK_KEY(CHECK_KEY), .SUM_W(SUM_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .start(start), .cause(cause), .dl_pin(dl_pin),
    .check_word(check_word), .sum_done(sum_done), .sum(sum),
    .run_user(run_user), .enter_loader(enter_loader), .page0_error(page0_error));

  idle_timer #(.PRESCALE(PRESCALE), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enter_loader), .activity(lin_frame_rx),
    .clear(start), .expire(power_down_req));

  // R9: power-down is only requested from the loader
  assert_pd_in_loader_R9: assert property (@(posedge clk) disable iff (!rst_n)
    power_down_req |-> enter_loader);
  // R1: an error flag always comes with a decision
  assert_err_with_decision_R1: assert property (@(posedge clk) disable iff (!rst_n)
    page0_error |-> (run_user || enter_loader));
endmodule

// File: tb/test_boot_mode_decider.sv
module test_boot_mode_decider;
  localparam int PRE = 4;
  localparam int TKS = 5;
  localparam logic [31:0] KEY = 32'h2701_1970;

  logic clk = 1'b0;
  logic rst_n, start, dl_pin, hw_valid, lin_frame_rx;
  logic [1:0] cause;
  logic [31:0] check_word;
  logic [15:0] hw_data;
  logic run_user, enter_loader, page0_error, power_down_req;

  int checks = 0;
  int failures = 0;
  logic [15:0] page [256];

  always #5 clk = ~clk;

  boot_mode_decider #(.PRESCALE(PRE), .TIMEOUT_TICKS(TKS)) i_boot_mode_decider (
    .clk(clk), .rst_n(rst_n), .start(start), .cause(cause), .dl_pin(dl_pin),
    .check_word(check_word), .hw_valid(hw_valid), .hw_data(hw_data),
    .lin_frame_rx(lin_frame_rx), .run_user(run_user), .enter_loader(enter_loader),
    .page0_error(page0_error), .power_down_req(power_down_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] page_sum();
    logic [31:0] s = 0;
    for (int i = 0; i < 256; i++)
      if (i != 10 && i != 11) s = s + {16'h0, page[i]};
    return s;
  endfunction

  // {run_user, enter_loader, page0_error}
  function automatic logic [2:0] model(input logic [1:0] c, input logic p, input logic [31:0] cw);
    logic pass, pin_ok, er, ld;
    er     = (cw == 32'hFFFF_FFFF);
    pass   = (cw == KEY) || (!er && cw == page_sum());
    pin_ok = (c[1] == 1'b0) ? !p : 1'b1;
    ld     = pin_ok && !pass;
    return {!ld, ld, !pass && !er};
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 256; i++) page[i] = 16'($urandom);
  endtask

  task automatic run_boot(input string req, input logic [1:0] c, input logic p, input logic [31:0] cw);
    @(negedge clk);
    start = 1'b1; cause = c; dl_pin = p; check_word = cw;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      start = 1'b0; hw_valid = 1'b1; hw_data = page[i];
    end
    @(negedge clk);
    hw_valid = 1'b0;
    chk({req, " R7 undecided before"}, {30'b0, run_user, enter_loader}, 32'd0);
    @(negedge clk);
    chk(req, {29'b0, run_user, enter_loader, page0_error}, {29'b0, model(c, p, cw)});
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; cause = 2'b00; dl_pin = 1'b0; check_word = '0;
    hw_valid = 1'b0; hw_data = '0; lin_frame_rx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {28'b0, run_user, enter_loader, page0_error, power_down_req}, 32'd0);

    // R7: junk before start is ignored
    hw_valid = 1'b1; hw_data = 16'hBEEF;
    repeat (5) @(negedge clk);
    hw_valid = 1'b0;
    fill_random();
    run_boot("R2 valid sum", 2'b00, 1'b0, page_sum());
    chk("R2 run_user", {31'b0, run_user}, 32'd1);

    // R7: extra half words after the page change nothing
    hw_valid = 1'b1; hw_data = 16'h1111;
    repeat (4) @(negedge clk);
    hw_valid = 1'b0;
    chk("R7 ignored after page", {29'b0, run_user, enter_loader, page0_error}, 32'b100);

    // R2 exclusion: only halves 10 and 11 differ
    fill_random();
    page[10] = 16'h1234; page[11] = 16'h5678;
    run_boot("R2 excluded words", 2'b01, 1'b0, page_sum());
    chk("R2 excluded run_user", {31'b0, run_user}, 32'd1);
    run_boot("R2 included sum fails", 2'b00, 1'b0, page_sum() + 32'h68AC);
    chk("R2 included error", {31'b0, page0_error}, 32'd1);

    // R3 key
    fill_random();
    run_boot("R3 key", 2'b00, 1'b0, KEY);
    chk("R3 key run_user", {31'b0, run_user}, 32'd1);

    // R5 mismatch held
    run_boot("R5 mismatch", 2'b00, 1'b0, page_sum() + 32'd7);
    repeat (10) @(negedge clk);
    chk("R5 held", {29'b0, run_user, enter_loader, page0_error}, 32'b011);

    // R6 pin rules
    run_boot("R6 pin high por", 2'b00, 1'b1, page_sum() + 32'd3);
    chk("R6 pin high run_user", {30'b0, run_user, page0_error}, 32'b11);
    run_boot("R6 wdt ignores pin", 2'b10, 1'b1, page_sum() + 32'd3);
    chk("R6 wdt loader", {31'b0, enter_loader}, 32'd1);
    run_boot("R6 sw ignores pin", 2'b11, 1'b1, 32'hFFFF_FFFF);

    // R4 erased, then timer R9 and R10
    run_boot("R4 erased", 2'b01, 1'b0, 32'hFFFF_FFFF);
    chk("R4 no error", {30'b0, enter_loader, page0_error}, 32'b10);
    repeat (19) @(negedge clk);
    chk("R9 not yet expired", {31'b0, power_down_req}, 32'd0);
    @(negedge clk);
    chk("R9 expired", {31'b0, power_down_req}, 32'd1);
    lin_frame_rx = 1'b1;
    @(negedge clk);
    lin_frame_rx = 1'b0;
    chk("R10 frame clears", {31'b0, power_down_req}, 32'd0);
    repeat (10) @(negedge clk);
    lin_frame_rx = 1'b1;
    @(negedge clk);
    lin_frame_rx = 1'b0;
    repeat (19) @(negedge clk);
    chk("R10 restart full", {31'b0, power_down_req}, 32'd0);
    @(negedge clk);
    chk("R10 expire after restart", {31'b0, power_down_req}, 32'd1);

    // R8 restart mid-page
    @(negedge clk);
    start = 1'b1; cause = 2'b00; dl_pin = 1'b0; check_word = 32'h0;
    @(negedge clk);
    start = 1'b0;
    chk("R8 cleared", {29'b0, enter_loader, page0_error, power_down_req}, 32'd0);
    for (int i = 0; i < 100; i++) begin
      hw_valid = 1'b1; hw_data = 16'hFFFF;
      @(negedge clk);
    end
    hw_valid = 1'b0;
    fill_random();
    run_boot("R8 restart", 2'b00, 1'b0, page_sum());
    chk("R8 restart run_user", {31'b0, run_user}, 32'd1);

    // random mix
    for (int n = 0; n < 20; n++) begin
      logic [31:0] cw;
      int kind;
      fill_random();
      kind = int'($urandom % 4);
      case (kind)
        0: cw = page_sum();
        1: cw = KEY;
        2: cw = 32'hFFFF_FFFF;
        default: cw = page_sum() + 32'd1 + ($urandom % 1000);
      endcase
      run_boot("R6 random", 2'($urandom), 1'($urandom), cw);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule